// File: doc/BRIEF.md
# Write Protection and Status Unit

This block keeps the status byte of a small serial non-volatile memory and decides, one request at a time, whether an array write or a status write may go ahead. A serial front end decodes the host's commands and hands this unit single-cycle strobes: set-enable, clear-enable, status write with its data byte, and array write with its target address. The array-write and status-write strobes are the commit requests, raised when the host completes a valid write frame. The unit answers each commit request one cycle later with a grant pulse or a deny pulse. After a grant it holds a busy flag for a fixed number of clock cycles, which stands for the self-timed programming interval.

Three things guard a write. The first is a volatile enable latch that an earlier command must set. The second is an active-low write-protect pin. The third is a two-bit protection level that shields the top quarter, the top half or the whole array. The status byte can be read on every cycle, including while a write is being committed. New protection and watchdog-period bits written to it take effect only when the programming interval ends.

Top module: `wps_unit`

## Requirements
- R1: Reset (synchronous, active high) leaves status_o = 8'h30, busy_o = 0, grant_o = 0 and deny_o = 0. The status byte layout is: bit0 busy flag, bit1 enable latch, bits 3:2 protection level, bits 5:4 watchdog period, bits 7:6 always 0.
- R2: When idle, a cmd_wren strobe sets status bit1 on the next cycle and a cmd_wrdi strobe clears it. If both strobes arrive together, the clear wins. While busy_o is high, both strobes are ignored.
- R3: A commit request (cmd_wrarr or cmd_wrsr) made while status bit1 is 0 gives a deny_o pulse on the next cycle and does not start a write.
- R4: While wp_n is 0, status bit1 is cleared at the next edge and held at 0, and every commit request is denied.
- R5: A granted request gives a grant_o pulse lasting exactly one cycle, on the cycle after the request. busy_o and status bit0 then stay high for exactly WRITE_CYCLES cycles, beginning on that same cycle.
- R6: If wp_n falls after a write has been granted, the programming interval still runs its full length.
- R7: Status bit1 clears on the cycle that busy_o falls.
- R8: The protection level selects the protected array range. With 00 nothing is protected. With 01, addresses 180h-1FFh are protected; with 10, 100h-1FFh; with 11, the whole array. An array write to a protected address is denied and leaves status bit1 unchanged. Status writes are never blocked by the protection level.
- R9: A granted status write copies data bits 3:2 into the protection level and bits 5:4 into the watchdog period on the cycle that busy_o falls. Until then the old values read back. Data bits 7:6 and 1:0 have no effect.
- R10: A commit request made while busy_o is high is denied and does not restart or extend the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wren | input | 1 | Set-enable command strobe |
| cmd_wrdi | input | 1 | Clear-enable command strobe |
| cmd_wrsr | input | 1 | Status-write commit request |
| cmd_wrarr | input | 1 | Array-write commit request |
| wr_addr | input | ADDR_W | Target byte address of an array write |
| sr_wdata | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| grant_o | output | 1 | One-cycle pulse: request accepted |
| deny_o | output | 1 | One-cycle pulse: request refused |
| busy_o | output | 1 | Programming interval in progress |
| status_o | output | 8 | Status byte |

## Verification
The bench probes the edges of each protected range. It writes 17Fh and 180h under level 01, and 0FFh and 100h under level 10. A range decoder off by one would grant the second address of a pair or deny the first. It lowers wp_n in the middle of a granted write and measures the busy length. A design that aborted the interval would show a shorter pulse. It sends a status write and reads the byte during the interval. A design that updated the bits at grant time would show the new protection level too early. It sends a clear-enable strobe while busy and expects the latch to stay set until completion. It also sends a commit request during the interval; a design that accepted it would stretch busy_o beyond WRITE_CYCLES cycles.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int STAT_W  = 8;
  localparam int WIP_POS = 0;
  localparam int WEL_POS = 1;
  localparam int BL_LSB  = 2;
  localparam int WD_LSB  = 4;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_t;

  localparam logic [1:0] WD_RESET = 2'b11;
endpackage

// File: rtl/wps_commit_timer.sv
module wps_commit_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);
endmodule

// File: rtl/wps_enable_latch.sv
module wps_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic wp_n,
  input  logic busy,
  input  logic done,
  output logic wel
);
  logic wel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0;
    end else if (!wp_n || done) begin
      wel_q <= 1'b0;
    end else if (!busy) begin
      if (clr_req) begin
        wel_q <= 1'b0;
      end else if (set_req) begin
        wel_q <= 1'b1;
      end
    end
  end

  assign wel = wel_q;
endmodule

// File: rtl/wps_write_guard.sv
module wps_write_guard #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_arr,
  input  logic              req_sr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lvl,
  input  logic              wel,
  input  logic              wp_n,
  input  logic              busy,
  output logic              accept,
  output logic              grant_q,
  output logic              deny_q
);
  import wps_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_QTR  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] BASE_HALF = {1'b1, {(ADDR_W-1){1'b0}}};

  logic in_range;
  logic req_any;

  always_comb begin
    unique case (prot_lvl_t'(lvl))
      PROT_NONE: in_range = 1'b0;
      PROT_QTR:  in_range = (addr >= BASE_QTR);
      PROT_HALF: in_range = (addr >= BASE_HALF);
      default:   in_range = 1'b1;
    endcase
  end

  assign req_any = req_arr | req_sr;
  assign accept  = req_any && wel && wp_n && !busy && (req_sr || !in_range);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= accept;
      deny_q  <= req_any && !accept;
    end
  end
endmodule

// File: rtl/wps_nv_bits.sv
module wps_nv_bits (
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic [1:0] new_lvl,
  input  logic [1:0] new_wd,
  input  logic       commit,
  output logic [1:0] lvl,
  output logic [1:0] wd
);
  import wps_pkg::*;

  logic [1:0] lvl_q, wd_q, lvl_pend, wd_pend;
  logic       pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= PROT_NONE;
      wd_q     <= WD_RESET;
      lvl_pend <= PROT_NONE;
      wd_pend  <= WD_RESET;
      pend_q   <= 1'b0;
    end else if (capture) begin
      lvl_pend <= new_lvl;
      wd_pend  <= new_wd;
      pend_q   <= 1'b1;
    end else if (commit && pend_q) begin
      lvl_q  <= lvl_pend;
      wd_q   <= wd_pend;
      pend_q <= 1'b0;
    end
  end

  assign lvl = lvl_q;
  assign wd  = wd_q;
endmodule

// File: rtl/wps_unit.sv
module wps_unit #(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_wrarr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  output logic              grant_o,
  output logic              deny_o,
  output logic              busy_o,
  output logic [7:0]        status_o
);
  import wps_pkg::*;

  logic       accept, busy, done, wel;
  logic [1:0] lvl, wd;
  logic       unused_data;

  assign unused_data = ^{sr_wdata[7:6], sr_wdata[1:0]};

  wps_commit_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .busy(busy), .done(done)
  );

  wps_enable_latch u_latch (
    .clk(clk), .rst(rst), .set_req(cmd_wren), .clr_req(cmd_wrdi),
    .wp_n(wp_n), .busy(busy), .done(done), .wel(wel)
  );

  wps_write_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst(rst), .req_arr(cmd_wrarr), .req_sr(cmd_wrsr),
    .addr(wr_addr), .lvl(lvl), .wel(wel), .wp_n(wp_n), .busy(busy),
    .accept(accept), .grant_q(grant_o), .deny_q(deny_o)
  );

  wps_nv_bits u_nv (
    .clk(clk), .rst(rst), .capture(accept && cmd_wrsr),
    .new_lvl(sr_wdata[BL_LSB+1:BL_LSB]), .new_wd(sr_wdata[WD_LSB+1:WD_LSB]),
    .commit(done), .lvl(lvl), .wd(wd)
  );

  assign busy_o   = busy;
  assign status_o = {2'b00, wd, lvl, wel, busy};
endmodule

// File: rtl/wps_unit_chk.sv
module wps_unit_chk #(
  parameter int WRITE_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic       grant_o,
  input logic       deny_o,
  input logic       busy_o,
  input logic [7:0] status_o
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (rst)         busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  AST_WP_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst) !wp_n |=> !status_o[1]); // R4
  AST_GRANT_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst) grant_o |-> $past(wp_n)); // R4
  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst) grant_o |-> $past(status_o[1])); // R3
  AST_GRANT_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst) grant_o |-> busy_o && !deny_o); // R5
  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) grant_o |=> !grant_o); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> busy_len == WRITE_CYCLES); // R5
  AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) grant_o |-> !$past(busy_o)); // R10
  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> !status_o[1]); // R7
  AST_NV_BITS_AT_END: assert property (@(posedge clk) disable iff (rst) !$stable(status_o[5:2]) |-> $fell(busy_o)); // R9
endmodule

bind wps_unit wps_unit_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_wps_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .grant_o(grant_o), .deny_o(deny_o),
  .busy_o(busy_o), .status_o(status_o)
);

// File: tb/test_wps_unit.sv
module test_wps_unit;
  localparam int AW = 9;
  localparam int WC = 16;
  localparam int K_WREN = 0, K_WRDI = 1, K_BOTH = 2, K_ARR = 3, K_SR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_wrarr = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] sr_wdata = '0;
  logic wp_n = 1'b1;
  logic grant_o, deny_o, busy_o;
  logic [7:0] status_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wps_unit #(.ADDR_W(AW), .WRITE_CYCLES(WC)) i_wps_unit (
    .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .cmd_wrarr(cmd_wrarr), .wr_addr(wr_addr),
    .sr_wdata(sr_wdata), .wp_n(wp_n), .grant_o(grant_o), .deny_o(deny_o),
    .busy_o(busy_o), .status_o(status_o)
  );

  // behavioural reference model
  int m_cnt = 0;
  bit m_wel = 0, m_grant = 0, m_deny = 0, m_pend = 0;
  int m_lvl = 0, m_wd = 3, p_lvl = 0, p_wd = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_wel = 0; m_grant = 0; m_deny = 0; m_pend = 0;
      m_lvl = 0; m_wd = 3;
    end else begin
      bit req, prot, acc, fin;
      int a;
      a = int'(wr_addr);
      req = cmd_wrarr || cmd_wrsr;
      prot = (m_lvl == 3) || (m_lvl == 2 && a >= 256) || (m_lvl == 1 && a >= 384);
      acc = req && m_wel && wp_n && (m_cnt == 0) && (cmd_wrsr || !prot);
      fin = (m_cnt == 1);
      m_grant = acc;
      m_deny = req && !acc;
      if (!wp_n || fin) m_wel = 0;
      else if (m_cnt == 0) begin
        if (cmd_wrdi) m_wel = 0;
        else if (cmd_wren) m_wel = 1;
      end
      if (fin && m_pend) begin m_lvl = p_lvl; m_wd = p_wd; m_pend = 0; end
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      if (acc) begin
        m_cnt = WC;
        if (cmd_wrsr) begin m_pend = 1; p_lvl = int'(sr_wdata[3:2]); p_wd = int'(sr_wdata[5:4]); end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R5 model busy", int'(busy_o), int'(m_cnt != 0));
      chk("R2 model latch", int'(status_o[1]), int'(m_wel));
      chk("R9 model fields", int'(status_o[7:2]), m_wd * 4 + m_lvl);
      chk("R3 model answer", int'({grant_o, deny_o}), int'({m_grant, m_deny}));
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_cmd(input int kind, input int addr, input int data);
    cmd_wren  = (kind == K_WREN || kind == K_BOTH);
    cmd_wrdi  = (kind == K_WRDI || kind == K_BOTH);
    cmd_wrarr = (kind == K_ARR);
    cmd_wrsr  = (kind == K_SR);
    wr_addr   = AW'(addr);
    sr_wdata  = 8'(data);
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrarr = 0; cmd_wrsr = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic expect_answer(input string req, input bit g);
    chk(req, int'({grant_o, deny_o}), g ? 2 : 1);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 reset status", int'(status_o), 'h30);
    chk("R1 reset outputs", int'({grant_o, deny_o, busy_o}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 status after release", int'(status_o), 'h30);

    do_cmd(K_WREN, 0, 0); chk("R2 set latch", int'(status_o[1]), 1);
    do_cmd(K_WRDI, 0, 0); chk("R2 clear latch", int'(status_o[1]), 0);
    do_cmd(K_WREN, 0, 0); do_cmd(K_BOTH, 0, 0); chk("R2 clear wins", int'(status_o[1]), 0);

    do_cmd(K_ARR, 'h010, 0); expect_answer("R3 deny without latch", 0);
    chk("R3 no busy", int'(busy_o), 0);

    do_cmd(K_WREN, 0, 0);
    wp_n = 0; @(negedge clk); chk("R4 pin clears latch", int'(status_o[1]), 0);
    do_cmd(K_WREN, 0, 0); chk("R4 latch held low", int'(status_o[1]), 0);
    do_cmd(K_SR, 0, 'h00); expect_answer("R4 deny under pin", 0);
    wp_n = 1; @(negedge clk);

    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h020, 0);
    expect_answer("R5 grant", 1);
    chk("R5 busy bit", int'(status_o[0]), 1);
    do_cmd(K_ARR, 'h021, 0); expect_answer("R10 deny while busy", 0);
    chk("R5 grant one cycle", int'(grant_o), 0);
    n = 2;
    forever begin
      @(negedge clk);
      if (busy_o) n++; else break;
    end
    chk("R10 length not extended", n, WC);
    chk("R7 latch cleared at end", int'(status_o[1]), 0);

    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h030, 0);
    expect_answer("R6 grant", 1);
    wp_n = 0;
    n = 1;
    forever begin
      @(negedge clk);
      if (busy_o) n++; else break;
    end
    chk("R6 full length under pin", n, WC);
    wp_n = 1; @(negedge clk);

    do_cmd(K_WREN, 0, 0); do_cmd(K_SR, 0, 'hFB);
    expect_answer("R9 status write grant", 1);
    chk("R9 old bits during write", int'(status_o[5:2]), 'hC);
    do_cmd(K_WRDI, 0, 0); chk("R2 clear ignored while busy", int'(status_o[1]), 1);
    wait_idle(); chk("R9 new bits", int'(status_o), 'h38);
    do_cmd(K_WREN, 0, 0); do_cmd(K_SR, 0, 'h00); wait_idle();
    chk("R9 period cleared", int'(status_o), 'h00);

    do_cmd(K_WREN, 0, 0); do_cmd(K_SR, 0, 'h0C); wait_idle();
    chk("R8 level all", int'(status_o), 'h0C);
    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h000, 0); expect_answer("R8 all blocks 000", 0);
    chk("R8 latch kept", int'(status_o[1]), 1);
    do_cmd(K_SR, 0, 'h14); expect_answer("R8 status write not blocked", 1);
    wait_idle(); chk("R8 level quarter", int'(status_o), 'h14);
    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h17F, 0); expect_answer("R8 17F open", 1);
    wait_idle();
    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h180, 0); expect_answer("R8 180 locked", 0);
    do_cmd(K_SR, 0, 'h28); expect_answer("R8 status write", 1);
    wait_idle();
    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h0FF, 0); expect_answer("R8 0FF open", 1);
    wait_idle();
    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h100, 0); expect_answer("R8 100 locked", 0);
    do_cmd(K_ARR, 'h1FF, 0); expect_answer("R8 1FF locked", 0);
    do_cmd(K_SR, 0, 'h30); wait_idle();
    do_cmd(K_WREN, 0, 0); do_cmd(K_ARR, 'h1FF, 0); expect_answer("R8 none open", 1);
    wait_idle();
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule